// File: doc/BRIEF.md
# Flash command decoder

This block is the command front end of a parallel NOR flash with byte-wide data and a 20-bit address. It watches host write cycles and decodes one-byte and two-byte command sequences. It chooses what host reads return: the array, the identifier space, or the status byte. Erase, program and lock-bit changes go to a write state machine as one-cycle start pulses, together with the latched address and data. The write state machine reports completion on a done input.

Lock permissions are judged inside the block. It holds one lock bit per block and a single master lock bit. A high-voltage-present input tells it whether the reset pin is above its normal level. A refused operation records an error in the status byte, and no start pulse is sent. The most significant `BLK_W` address bits select the block.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the read mode is array (`rd_mode` = 0), `status_byte` is 0x80, no start output is high, and every lock bit is clear.
- R2: While idle or suspended, a write of 0xFF selects array reads (`rd_mode` = 0), 0x90 selects identifier reads (1), and 0x70 selects status reads (2). `rd_mode` changes only in a cycle with `host_we` high.
- R3: Status byte layout: bit 7 ready, bit 6 erase suspended, bit 5 erase/clear-lock error, bit 4 program/set-lock error, bit 3 lock violation, bit 2 program suspended, bits 1:0 zero. A write of 0x50 while idle or suspended clears bits 5, 4 and 3.
- R4: A write of 0x20 followed by 0xD0 to an address in the same block pulses `erase_go` for one cycle, with `op_addr` set to the confirm address. Status bit 7 then drops and `rd_mode` becomes 2.
- R5: A write of 0x40 or 0x10 followed by any data write pulses `prog_go`, with `op_addr`/`op_data` set to that second write's address and data.
- R6: After 0x60, a second byte of 0x01 pulses `blk_lock_go` and locks the addressed block, 0xF1 pulses `master_lock_go` and sets the master bit, and 0xD0 pulses `lock_clear_go` and clears every block lock bit.
- R7: Erase or program of a locked block with `hv_unlock` low sends no pulse. It sets bit 3, plus bit 5 for an erase or bit 4 for a program. With `hv_unlock` high the operation starts.
- R8: Setting the master bit needs `hv_unlock`. When the master bit is set, a block lock set or a lock clear also needs it. A refused set raises bits 4 and 3, and a refused clear raises bits 5 and 3.
- R9: A wrong second byte, or an erase confirm in a different block, sends no pulse, sets bits 5 and 4, and leaves `rd_mode` = 2.
- R10: A first-cycle write of any code outside the defined set changes neither `rd_mode` nor `status_byte`, and raises no output pulse.
- R11: While busy, writes are ignored except 0xB0 during an erase or program. That write pulses `suspend_go`, sets bit 7, and sets bit 6 (erase) or bit 2 (program). 0xB0 during a lock operation is ignored.
- R12: While suspended, 0xD0 pulses `resume_go`, clears the suspend bit, drops bit 7 and sets `rd_mode` = 2.
- R13: `wsm_done` while busy returns to ready (bit 7 = 1). It takes priority over a suspend write in the same cycle, in which case no `suspend_go` is raised. `wsm_done` has no effect while not busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | One-cycle host write strobe |
| host_addr | input | ADDR_W | Host write address |
| host_data | input | DATA_W | Host write data / command code |
| hv_unlock | input | 1 | High voltage present on the reset pin |
| wsm_done | input | 1 | Write state machine finished the running operation |
| rd_mode | output | 2 | Read source: 0 array, 1 identifier, 2 status |
| status_byte | output | 8 | Status register |
| erase_go | output | 1 | Block erase start pulse |
| prog_go | output | 1 | Program start pulse |
| blk_lock_go | output | 1 | Block lock-bit set start pulse |
| master_lock_go | output | 1 | Master lock-bit set start pulse |
| lock_clear_go | output | 1 | Clear-all-block-locks start pulse |
| suspend_go | output | 1 | Suspend request pulse |
| resume_go | output | 1 | Resume request pulse |
| op_addr | output | ADDR_W | Address latched for the started operation |
| op_data | output | DATA_W | Data latched for the started operation |

## Verification
The completion signal from the write state machine and a host suspend write can arrive in the same clock while an erase or program is running. The bench drives `wsm_done` and a 0xB0 write on one clock edge during a running erase. The reference model applies the completion first, so the bench expects ready status, no suspend pulse and no suspend bit in the next cycle. The per-clock comparison of every output would catch a stray `suspend_go` or a stuck suspended state.

// File: rtl/fcmd_pkg.sv
package fcmd_pkg;

  typedef enum logic [1:0] {
    RM_ARRAY  = 2'd0,
    RM_IDENT  = 2'd1,
    RM_STATUS = 2'd2
  } rmode_t;

  typedef enum logic [3:0] {
    C_RESERVED,
    C_READ_ARRAY,
    C_READ_ID,
    C_READ_STAT,
    C_CLR_STAT,
    C_ERASE_SETUP,
    C_PROG_SETUP,
    C_LOCK_SETUP,
    C_SUSPEND,
    C_CONFIRM
  } cmd_t;

  typedef enum logic [1:0] {
    OP_NONE,
    OP_ERASE,
    OP_PROG,
    OP_LOCK
  } op_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT2,
    ST_BUSY,
    ST_SUSP
  } ctl_t;

  localparam logic [7:0] CODE_READ_ARRAY = 8'hFF;
  localparam logic [7:0] CODE_READ_ID    = 8'h90;
  localparam logic [7:0] CODE_READ_STAT  = 8'h70;
  localparam logic [7:0] CODE_CLR_STAT   = 8'h50;
  localparam logic [7:0] CODE_ERASE      = 8'h20;
  localparam logic [7:0] CODE_PROG_A     = 8'h40;
  localparam logic [7:0] CODE_PROG_B     = 8'h10;
  localparam logic [7:0] CODE_LOCK       = 8'h60;
  localparam logic [7:0] CODE_SUSPEND    = 8'hB0;
  localparam logic [7:0] CODE_CONFIRM    = 8'hD0;
  localparam logic [7:0] CODE_LK_BLOCK   = 8'h01;
  localparam logic [7:0] CODE_LK_MASTER  = 8'hF1;

endpackage

// File: rtl/fcmd_classify.sv
module fcmd_classify
  import fcmd_pkg::*;
(
  input  logic [7:0] code,
  output cmd_t       kind
);
  always_comb begin
    case (code)
      CODE_READ_ARRAY:          kind = C_READ_ARRAY;
      CODE_READ_ID:             kind = C_READ_ID;
      CODE_READ_STAT:           kind = C_READ_STAT;
      CODE_CLR_STAT:            kind = C_CLR_STAT;
      CODE_ERASE:               kind = C_ERASE_SETUP;
      CODE_PROG_A, CODE_PROG_B: kind = C_PROG_SETUP;
      CODE_LOCK:                kind = C_LOCK_SETUP;
      CODE_SUSPEND:             kind = C_SUSPEND;
      CODE_CONFIRM:             kind = C_CONFIRM;
      default:                  kind = C_RESERVED;
    endcase
  end
endmodule

// File: rtl/fcmd_locks.sv
module fcmd_locks #(
  parameter int BLK_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [BLK_W-1:0] idx,
  input  logic             set_one,
  input  logic             set_master,
  input  logic             clear_all,
  output logic             sel_locked,
  output logic             master_locked
);
  localparam int NBLK = 1 << BLK_W;

  logic [NBLK-1:0] lk;

  for (genvar g = 0; g < NBLK; g++) begin : g_blk
    always_ff @(posedge clk) begin
      if (rst)                                  lk[g] <= 1'b0;
      else if (clear_all)                       lk[g] <= 1'b0;
      else if (set_one && idx == BLK_W'(g))     lk[g] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)             master_locked <= 1'b0;
    else if (set_master) master_locked <= 1'b1;
  end

  assign sel_locked = lk[idx];
endmodule

// File: rtl/fcmd_status.sv
module fcmd_status (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       set_erase_err,
  input  logic       set_prog_err,
  input  logic       set_viol,
  input  logic       busy,
  input  logic       susp_erase,
  input  logic       susp_prog,
  output logic [7:0] status_byte
);
  logic erase_err, prog_err, viol;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      erase_err <= 1'b0;
      prog_err  <= 1'b0;
      viol      <= 1'b0;
    end else begin
      if (set_erase_err) erase_err <= 1'b1;
      if (set_prog_err)  prog_err  <= 1'b1;
      if (set_viol)      viol      <= 1'b1;
    end
  end

  assign status_byte = {~busy, susp_erase, erase_err, prog_err, viol,
                        susp_prog, 2'b00};
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import fcmd_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8,
  parameter int BLK_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_data,
  input  logic              hv_unlock,
  input  logic              wsm_done,
  output logic [1:0]        rd_mode,
  output logic [7:0]        status_byte,
  output logic              erase_go,
  output logic              prog_go,
  output logic              blk_lock_go,
  output logic              master_lock_go,
  output logic              lock_clear_go,
  output logic              suspend_go,
  output logic              resume_go,
  output logic [ADDR_W-1:0] op_addr,
  output logic [DATA_W-1:0] op_data
);
  localparam int BLK_LSB = ADDR_W - BLK_W;

  ctl_t             state, state_n;
  op_t              pend_kind, pend_kind_n, run_kind, run_kind_n;
  rmode_t           mode_q, mode_n;
  logic [BLK_W-1:0] pend_blk, pend_blk_n, cur_blk;
  cmd_t             cmd;
  logic             sel_locked, master_locked;
  logic             e_d, p_d, bl_d, ml_d, lc_d, sp_d, rs_d, ld_op;
  logic             clr_st, set_e, set_p, set_v;
  logic [7:0]       code;

  assign code    = host_data[7:0];
  assign cur_blk = host_addr[ADDR_W-1:BLK_LSB];

  fcmd_classify u_cls (.code(code), .kind(cmd));

  fcmd_locks #(.BLK_W(BLK_W)) u_lk (
    .clk(clk), .rst(rst), .idx(cur_blk),
    .set_one(bl_d), .set_master(ml_d), .clear_all(lc_d),
    .sel_locked(sel_locked), .master_locked(master_locked)
  );

  fcmd_status u_st (
    .clk(clk), .rst(rst), .clr(clr_st),
    .set_erase_err(set_e), .set_prog_err(set_p), .set_viol(set_v),
    .busy(state == ST_BUSY),
    .susp_erase(state == ST_SUSP && run_kind == OP_ERASE),
    .susp_prog(state == ST_SUSP && run_kind == OP_PROG),
    .status_byte(status_byte)
  );

  always_comb begin
    state_n     = state;
    mode_n      = mode_q;
    pend_kind_n = pend_kind;
    pend_blk_n  = pend_blk;
    run_kind_n  = run_kind;
    {e_d, p_d, bl_d, ml_d, lc_d, sp_d, rs_d, ld_op} = '0;
    {clr_st, set_e, set_p, set_v} = '0;
    case (state)
      ST_IDLE, ST_SUSP: if (host_we) begin
        case (cmd)
          C_READ_ARRAY: mode_n = RM_ARRAY;
          C_READ_ID:    mode_n = RM_IDENT;
          C_READ_STAT:  mode_n = RM_STATUS;
          C_CLR_STAT:   clr_st = 1'b1;
          C_ERASE_SETUP, C_PROG_SETUP, C_LOCK_SETUP:
            if (state == ST_IDLE) begin
              state_n     = ST_WAIT2;
              mode_n      = RM_STATUS;
              pend_blk_n  = cur_blk;
              pend_kind_n = (cmd == C_ERASE_SETUP) ? OP_ERASE :
                            (cmd == C_PROG_SETUP)  ? OP_PROG  : OP_LOCK;
            end
          C_CONFIRM:
            if (state == ST_SUSP) begin
              rs_d    = 1'b1;
              state_n = ST_BUSY;
              mode_n  = RM_STATUS;
            end
          default: ;
        endcase
      end
      ST_WAIT2: if (host_we) begin
        state_n     = ST_IDLE;
        mode_n      = RM_STATUS;
        pend_kind_n = OP_NONE;
        case (pend_kind)
          OP_ERASE:
            if (code != CODE_CONFIRM || cur_blk != pend_blk) begin
              set_e = 1'b1; set_p = 1'b1;
            end else if (sel_locked && !hv_unlock) begin
              set_e = 1'b1; set_v = 1'b1;
            end else begin
              e_d = 1'b1; ld_op = 1'b1;
              state_n = ST_BUSY; run_kind_n = OP_ERASE;
            end
          OP_PROG:
            if (sel_locked && !hv_unlock) begin
              set_p = 1'b1; set_v = 1'b1;
            end else begin
              p_d = 1'b1; ld_op = 1'b1;
              state_n = ST_BUSY; run_kind_n = OP_PROG;
            end
          default:
            if (code == CODE_LK_BLOCK) begin
              if (master_locked && !hv_unlock) begin
                set_p = 1'b1; set_v = 1'b1;
              end else begin
                bl_d = 1'b1; ld_op = 1'b1;
                state_n = ST_BUSY; run_kind_n = OP_LOCK;
              end
            end else if (code == CODE_LK_MASTER) begin
              if (!hv_unlock) begin
                set_p = 1'b1; set_v = 1'b1;
              end else begin
                ml_d = 1'b1; ld_op = 1'b1;
                state_n = ST_BUSY; run_kind_n = OP_LOCK;
              end
            end else if (code == CODE_CONFIRM) begin
              if (master_locked && !hv_unlock) begin
                set_e = 1'b1; set_v = 1'b1;
              end else begin
                lc_d = 1'b1; ld_op = 1'b1;
                state_n = ST_BUSY; run_kind_n = OP_LOCK;
              end
            end else begin
              set_e = 1'b1; set_p = 1'b1;
            end
        endcase
      end
      default: begin
        if (wsm_done) begin
          state_n    = ST_IDLE;
          run_kind_n = OP_NONE;
        end else if (host_we && cmd == C_SUSPEND &&
                     (run_kind == OP_ERASE || run_kind == OP_PROG)) begin
          sp_d    = 1'b1;
          state_n = ST_SUSP;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      mode_q    <= RM_ARRAY;
      pend_kind <= OP_NONE;
      pend_blk  <= '0;
      run_kind  <= OP_NONE;
      {erase_go, prog_go, blk_lock_go, master_lock_go} <= '0;
      {lock_clear_go, suspend_go, resume_go}           <= '0;
      op_addr   <= '0;
      op_data   <= '0;
    end else begin
      state          <= state_n;
      mode_q         <= mode_n;
      pend_kind      <= pend_kind_n;
      pend_blk       <= pend_blk_n;
      run_kind       <= run_kind_n;
      erase_go       <= e_d;
      prog_go        <= p_d;
      blk_lock_go    <= bl_d;
      master_lock_go <= ml_d;
      lock_clear_go  <= lc_d;
      suspend_go     <= sp_d;
      resume_go      <= rs_d;
      if (ld_op) begin
        op_addr <= host_addr;
        op_data <= host_data;
      end
    end
  end

  assign rd_mode = mode_q;
endmodule

// File: rtl/fcmd_ctrl_checks.sv
module fcmd_ctrl_checks (
  input logic       clk,
  input logic       rst,
  input logic       host_we,
  input logic       hv_unlock,
  input logic       wsm_done,
  input logic [1:0] rd_mode,
  input logic [7:0] status_byte,
  input logic       erase_go,
  input logic       prog_go,
  input logic       blk_lock_go,
  input logic       master_lock_go,
  input logic       lock_clear_go,
  input logic       suspend_go,
  input logic       resume_go
);
  logic any_start;
  assign any_start = erase_go | prog_go | blk_lock_go | master_lock_go | lock_clear_go;

  assert_one_start_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({erase_go, prog_go, blk_lock_go, master_lock_go, lock_clear_go,
              suspend_go, resume_go}));

  assert_start_busy_R4: assert property (@(posedge clk) disable iff (rst)
    any_start |-> !status_byte[7]);

  assert_mode_on_write_R2: assert property (@(posedge clk) disable iff (rst)
    !host_we |=> $stable(rd_mode));

  assert_viol_no_start_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(status_byte[3]) |-> !any_start);

  assert_master_needs_hv_R8: assert property (@(posedge clk) disable iff (rst)
    master_lock_go |-> $past(hv_unlock));

  assert_suspend_ready_R11: assert property (@(posedge clk) disable iff (rst)
    suspend_go |-> (status_byte[7] && (status_byte[6] || status_byte[2])));

  assert_resume_busy_R12: assert property (@(posedge clk) disable iff (rst)
    resume_go |-> (!status_byte[7] && !status_byte[6] && !status_byte[2]));

  assert_done_ready_R13: assert property (@(posedge clk) disable iff (rst)
    (wsm_done && !status_byte[7]) |=> status_byte[7]);
endmodule

bind flash_cmd_ctrl fcmd_ctrl_checks u_chk (
  .clk(clk), .rst(rst), .host_we(host_we), .hv_unlock(hv_unlock),
  .wsm_done(wsm_done), .rd_mode(rd_mode), .status_byte(status_byte),
  .erase_go(erase_go), .prog_go(prog_go), .blk_lock_go(blk_lock_go),
  .master_lock_go(master_lock_go), .lock_clear_go(lock_clear_go),
  .suspend_go(suspend_go), .resume_go(resume_go)
);

// File: tb/flash_cmd_ctrl_test.sv
module flash_cmd_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_we = 1'b0;
  logic [19:0] host_addr = '0;
  logic [7:0]  host_data = '0;
  logic        hv_unlock = 1'b0;
  logic        wsm_done = 1'b0;
  logic [1:0]  rd_mode;
  logic [7:0]  status_byte;
  logic        erase_go, prog_go, blk_lock_go, master_lock_go, lock_clear_go;
  logic        suspend_go, resume_go;
  logic [19:0] op_addr;
  logic [7:0]  op_data;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_ctrl uut (
    .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
    .host_data(host_data), .hv_unlock(hv_unlock), .wsm_done(wsm_done),
    .rd_mode(rd_mode), .status_byte(status_byte), .erase_go(erase_go),
    .prog_go(prog_go), .blk_lock_go(blk_lock_go),
    .master_lock_go(master_lock_go), .lock_clear_go(lock_clear_go),
    .suspend_go(suspend_go), .resume_go(resume_go),
    .op_addr(op_addr), .op_data(op_data)
  );

  // Reference model: state 0 idle, 1 second byte, 2 busy, 3 suspended
  // run kind: 0 none, 1 erase, 2 program, 3 lock
  int         m_st, m_pend, m_run, m_pblk, m_mode;
  bit         m_ee, m_pe, m_vi, m_master;
  bit [15:0]  m_lk;
  bit [6:0]   m_go;  // erase, prog, blklock, master, clear, suspend, resume
  bit [19:0]  m_oa;
  bit [7:0]   m_od;

  function automatic bit [7:0] m_status();
    return {m_st != 2, m_st == 3 && m_run == 1, m_ee, m_pe, m_vi,
            m_st == 3 && m_run == 2, 2'b00};
  endfunction

  task automatic m_launch(int kind, bit [6:0] g);
    m_go = g; m_oa = host_addr; m_od = host_data; m_st = 2; m_run = kind;
  endtask

  always @(posedge clk) begin
    int blk;
    blk = int'(host_addr[19:16]);
    if (rst) begin
      m_st = 0; m_pend = 0; m_run = 0; m_pblk = 0; m_mode = 0;
      m_ee = 0; m_pe = 0; m_vi = 0; m_master = 0; m_lk = '0;
      m_go = '0; m_oa = '0; m_od = '0;
    end else begin
      m_go = '0;
      if (m_st == 2) begin
        if (wsm_done) begin m_st = 0; m_run = 0; end
        else if (host_we && host_data == 8'hB0 && (m_run == 1 || m_run == 2)) begin
          m_go = 7'b0000010; m_st = 3;
        end
      end else if (m_st == 1) begin
        if (host_we) begin
          m_mode = 2; m_st = 0;
          if (m_pend == 1) begin
            if (host_data != 8'hD0 || blk != m_pblk) begin m_ee = 1; m_pe = 1; end
            else if (m_lk[blk] && !hv_unlock) begin m_ee = 1; m_vi = 1; end
            else m_launch(1, 7'b1000000);
          end else if (m_pend == 2) begin
            if (m_lk[blk] && !hv_unlock) begin m_pe = 1; m_vi = 1; end
            else m_launch(2, 7'b0100000);
          end else begin
            if (host_data == 8'h01) begin
              if (m_master && !hv_unlock) begin m_pe = 1; m_vi = 1; end
              else begin m_launch(3, 7'b0010000); m_lk[blk] = 1; end
            end else if (host_data == 8'hF1) begin
              if (!hv_unlock) begin m_pe = 1; m_vi = 1; end
              else begin m_launch(3, 7'b0001000); m_master = 1; end
            end else if (host_data == 8'hD0) begin
              if (m_master && !hv_unlock) begin m_ee = 1; m_vi = 1; end
              else begin m_launch(3, 7'b0000100); m_lk = '0; end
            end else begin m_ee = 1; m_pe = 1; end
          end
        end
      end else if (host_we) begin
        if (host_data == 8'hFF) m_mode = 0;
        else if (host_data == 8'h90) m_mode = 1;
        else if (host_data == 8'h70) m_mode = 2;
        else if (host_data == 8'h50) begin m_ee = 0; m_pe = 0; m_vi = 0; end
        else if (m_st == 0 && (host_data == 8'h20 || host_data == 8'h40 ||
                 host_data == 8'h10 || host_data == 8'h60)) begin
          m_st = 1; m_mode = 2; m_pblk = blk;
          m_pend = (host_data == 8'h20) ? 1 : (host_data == 8'h60) ? 3 : 2;
        end else if (m_st == 3 && host_data == 8'hD0) begin
          m_go = 7'b0000001; m_st = 2; m_mode = 2;
        end
      end
    end
  end

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-clock comparison against the model
  always @(negedge clk) begin
    if (!rst && !finished) begin
      check(rd_mode == 2'(m_mode), "R2 read mode", 32'(rd_mode), 32'(m_mode));
      check(status_byte == m_status(), "R3 status byte", 32'(status_byte),
            32'(m_status()));
      check({erase_go, prog_go, blk_lock_go, master_lock_go, lock_clear_go,
             suspend_go, resume_go} == m_go, "R6 start pulses",
            32'({erase_go, prog_go, blk_lock_go, master_lock_go, lock_clear_go,
                 suspend_go, resume_go}), 32'(m_go));
      check(op_addr == m_oa && op_data == m_od, "R5 op addr/data",
            {4'h0, op_addr, op_data}, {4'h0, m_oa, m_od});
    end
  end

  task automatic wr(logic [19:0] a, logic [7:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_data = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic done_pulse();
    @(negedge clk);
    wsm_done = 1'b1;
    @(negedge clk);
    wsm_done = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(rd_mode == 2'd0 && status_byte == 8'h80, "R1 reset", 32'(status_byte), 32'h80);

    // R2 read modes
    wr(20'h00000, 8'h90); check(rd_mode == 2'd1, "R2 ident", 32'(rd_mode), 1);
    wr(20'h00000, 8'h70); check(rd_mode == 2'd2, "R2 status", 32'(rd_mode), 2);
    wr(20'h00000, 8'hFF); check(rd_mode == 2'd0, "R2 array", 32'(rd_mode), 0);

    // R10 reserved first-cycle codes
    wr(20'h00000, 8'h33); wr(20'h00000, 8'h01); wr(20'h00000, 8'hD0);
    check(rd_mode == 2'd0 && status_byte == 8'h80, "R10 reserved", 32'(status_byte), 32'h80);

    // R13 done while idle ignored
    done_pulse();
    check(status_byte == 8'h80, "R13 idle done", 32'(status_byte), 32'h80);

    // R4 erase, R11 ignored writes while busy
    wr(20'h30000, 8'h20);
    wr(20'h3ABCD, 8'hD0);
    check(erase_go && op_addr == 20'h3ABCD, "R4 erase start", 32'(op_addr), 32'h3ABCD);
    wr(20'h00000, 8'hFF);
    check(rd_mode == 2'd2 && status_byte == 8'h00, "R11 busy ignore", 32'(status_byte), 0);
    done_pulse();
    check(status_byte == 8'h80, "R13 done ready", 32'(status_byte), 32'h80);

    // R5 program (0x10), R11 suspend, R12 resume
    wr(20'h12000, 8'h10);
    wr(20'h12345, 8'h5A);
    check(prog_go && op_data == 8'h5A, "R5 program", 32'(op_data), 32'h5A);
    wr(20'h00000, 8'hB0);
    check(status_byte == 8'h84, "R11 prog suspend", 32'(status_byte), 32'h84);
    wr(20'h00000, 8'hFF);
    wr(20'h00000, 8'hD0);
    check(status_byte == 8'h00 && rd_mode == 2'd2, "R12 resume", 32'(status_byte), 0);
    done_pulse();

    // R9 bad confirm and cross-block confirm, R3 clear
    wr(20'h10000, 8'h20); wr(20'h10000, 8'h77);
    check(status_byte == 8'hB0, "R9 bad confirm", 32'(status_byte), 32'hB0);
    wr(20'h00000, 8'h50);
    wr(20'h10000, 8'h20); wr(20'h20000, 8'hD0);
    check(status_byte == 8'hB0, "R9 other block", 32'(status_byte), 32'hB0);
    wr(20'h00000, 8'h50);
    check(status_byte == 8'h80, "R3 clear", 32'(status_byte), 32'h80);

    // R6 block lock, R7 locked block refusals
    wr(20'h50000, 8'h60); wr(20'h50010, 8'h01);
    check(blk_lock_go == 1'b1, "R6 block lock", 32'(blk_lock_go), 1);
    done_pulse();
    wr(20'h50000, 8'h20); wr(20'h50000, 8'hD0);
    check(status_byte == 8'hA8, "R7 locked erase", 32'(status_byte), 32'hA8);
    wr(20'h00000, 8'h50);
    wr(20'h50000, 8'h40); wr(20'h50001, 8'h11);
    check(status_byte == 8'h98, "R7 locked program", 32'(status_byte), 32'h98);
    wr(20'h00000, 8'h50);
    hv_unlock = 1'b1;
    wr(20'h50000, 8'h40); wr(20'h50002, 8'h22);
    check(prog_go == 1'b1, "R7 program with hv", 32'(prog_go), 1);
    done_pulse();
    hv_unlock = 1'b0;

    // R8 master lock rules
    wr(20'h00000, 8'h60); wr(20'h00000, 8'hF1);
    check(status_byte == 8'h98, "R8 master no hv", 32'(status_byte), 32'h98);
    wr(20'h00000, 8'h50);
    hv_unlock = 1'b1;
    wr(20'h00000, 8'h60); wr(20'h00000, 8'hF1);
    check(master_lock_go == 1'b1, "R8 master hv", 32'(master_lock_go), 1);
    // R11 suspend during a lock operation is ignored
    wr(20'h00000, 8'hB0);
    check(status_byte == 8'h00, "R11 lock no suspend", 32'(status_byte), 0);
    done_pulse();
    hv_unlock = 1'b0;
    wr(20'h00000, 8'h60); wr(20'h00000, 8'hD0);
    check(status_byte == 8'hA8, "R8 clear no hv", 32'(status_byte), 32'hA8);
    wr(20'h00000, 8'h50);
    wr(20'h70000, 8'h60); wr(20'h70000, 8'h01);
    check(status_byte == 8'h98, "R8 blk set no hv", 32'(status_byte), 32'h98);
    wr(20'h00000, 8'h50);
    hv_unlock = 1'b1;
    wr(20'h00000, 8'h60); wr(20'h00000, 8'hD0);
    check(lock_clear_go == 1'b1, "R6 clear locks", 32'(lock_clear_go), 1);
    done_pulse();
    hv_unlock = 1'b0;

    // R13 done and suspend in the same cycle during an erase
    wr(20'h50000, 8'h20); wr(20'h5FFFF, 8'hD0);
    check(erase_go == 1'b1, "R7 erase after clear", 32'(erase_go), 1);
    @(negedge clk);
    host_we = 1'b1; host_data = 8'hB0; wsm_done = 1'b1;
    @(negedge clk);
    host_we = 1'b0; wsm_done = 1'b0;
    check(!suspend_go && status_byte == 8'h80, "R13 done beats suspend",
          32'(status_byte), 32'h80);

    // R5 alternate setup code, erase suspend bit
    wr(20'hE0000, 8'h40); wr(20'hE0004, 8'hC3);
    done_pulse();
    wr(20'hE0000, 8'h20); wr(20'hE0000, 8'hD0);
    wr(20'h00000, 8'hB0);
    check(status_byte == 8'hC0, "R11 erase suspend", 32'(status_byte), 32'hC0);
    wr(20'h00000, 8'h90);
    wr(20'h00000, 8'hD0);
    done_pulse();
    repeat (2) @(negedge clk);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      compared++; mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule